// File: doc/BRIEF.md
# In-Place Tree Reduction Engine

This block adds up the first `n` words of a small local array. It works the way a group of `n/2` parallel workers would, each pairing up elements in place. In each round the stride doubles, and every eligible worker adds a partner one stride away into its own even-numbered slot. After `ceil(log2 n)` rounds the total sits in element 0. The engine then latches that total into a result register and pulses `done`.

Software fills the array through a simple write port while the engine is idle. It then gives a one-cycle `start` together with the element count `n_len`, which may be any value from 1 to `MAX_N`, including counts that are not a power of two. All additions in a round happen in one clock. Elements at or beyond `n` never contribute. The array is overwritten by the partial sums, so it must be reloaded before the next job.

Top module: `tree_reduce`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `result` is 0.
- R2: While `busy` is 0, a cycle with `ld_en` high writes `ld_data` into element `ld_addr`. While `busy` is 1, `ld_en` is ignored and the array is unchanged.
- R3: A `start` sampled while idle raises `busy` in the next cycle. `busy` then stays high for exactly `ceil(log2 n)` + 1 cycles, and `busy` falls in the same cycle that `done` rises.
- R4: For a power-of-two `n`, `result` equals the sum of elements 0 to `n`-1.
- R5: For a non-power-of-two `n`, `result` equals the sum of elements 0 to `n`-1. Elements with index `n` or above do not contribute.
- R6: With `n` = 1 the engine runs zero rounds. `busy` is high for one cycle, and `result` equals element 0 unchanged.
- R7: Sums wrap modulo 2^`DATA_W`.
- R8: A `start` pulse while `busy` is 1 is ignored. The running job keeps its count, its timing and its result.
- R9: `result` keeps its value from one `done` until the next `done`, even when elements are reloaded in between.
- R10: `done` is high for exactly one cycle per job.
- R11: In any round, no element is both read as a partner and written as a target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle job request, honoured only while idle |
| n_len | input | $clog2(MAX_N+1) | Element count for the job, 1 to MAX_N |
| ld_en | input | 1 | Array write strobe |
| ld_addr | input | $clog2(MAX_N) | Array write index |
| ld_data | input | DATA_W | Array write value |
| busy | output | 1 | High from the cycle after start until the result is latched |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | DATA_W | Sum of the last job, held until the next job finishes |

## Verification
The assertions assume that `n_len` is between 1 and `MAX_N` whenever `start` is sampled. They also assume that `ld_addr` stays below `MAX_N`. The bench never asks for a count of zero or above `MAX_N`, and it writes only valid indices. Before every job the bench reloads all `MAX_N` elements, so the in-place partial sums left by the previous job never leak into the expected totals. Requests made while busy, both starts and loads, are injected in the first running cycle. This is exactly where a faulty design would restart or corrupt element 0.

// File: rtl/tree_reduce_pkg.sv
// Package: shared types for the tree reduction engine.
// Assumes nothing beyond standard SystemVerilog.
package tree_reduce_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } red_state_t;
endpackage

// File: rtl/tr_elig.sv
// Worker eligibility decoder.
// For a round index j, worker i is active when i is a multiple of 2^j and
// 2i + 2^j is below the job count. Pure combinational logic.
// Assumes the round index stays below $clog2(MAX_N).
module tr_elig #(
    parameter int MAX_N = 16
) (
    input  logic [$clog2($clog2(MAX_N)+1)-1:0] round,
    input  logic [$clog2(MAX_N+1)-1:0]         n_q,
    output logic [MAX_N/2-1:0]                 active
);
    localparam int IDX_W = $clog2(MAX_N);
    localparam int CW    = IDX_W + 2;
    localparam int NW    = MAX_N / 2;

    logic [CW-1:0] stride;
    logic [CW-1:0] low_mask;

    // Stride and alignment mask for the current round.
    always_comb begin
        stride   = CW'(1) << round;
        low_mask = stride - CW'(1);
    end

    for (genvar i = 0; i < NW; i++) begin : g_wk
        logic [CW-1:0] partner;
        // Partner index and the two-part eligibility test for worker i.
        always_comb begin
            partner   = CW'(2 * i) + stride;
            active[i] = ((CW'(i) & low_mask) == '0) && (partner < CW'(n_q));
        end
    end
endmodule

// File: rtl/tr_ctrl.sv
// Round sequencer and result register.
// It latches the count on an idle start, steps the round counter once per
// cycle, then spends one cycle capturing element 0 into the result.
// Assumes n_len is within 1..MAX_N when start is sampled.
module tr_ctrl
    import tree_reduce_pkg::*;
#(
    parameter int MAX_N  = 16,
    parameter int DATA_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [$clog2(MAX_N+1)-1:0]         n_len,
    input  logic [DATA_W-1:0]                  elem0,
    output logic [$clog2(MAX_N+1)-1:0]         n_q,
    output logic [$clog2($clog2(MAX_N)+1)-1:0] round,
    output logic                               run,
    output logic                               busy,
    output logic                               done,
    output logic [DATA_W-1:0]                  result
);
    localparam int LOG_N = $clog2(MAX_N);
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam int RND_W = $clog2(LOG_N + 1);

    red_state_t       state;
    logic [RND_W-1:0] rounds_q;
    logic [RND_W-1:0] rnd_need;
    logic [RND_W-1:0] last_rnd;

    // Number of rounds a count needs: smallest r with 2^r >= n.
    function automatic logic [RND_W-1:0] rounds_for(input logic [CNT_W-1:0] n);
        logic [RND_W-1:0] r;
        r = '0;
        for (int k = 0; k <= LOG_N; k++) begin
            if ((32'd1 << k) < 32'(n)) r = RND_W'(k + 1);
        end
        return r;
    endfunction

    // Rounds needed by the requested count, and the last round index.
    always_comb begin
        rnd_need = rounds_for(n_len);
        last_rnd = rounds_q - RND_W'(1);
    end

    // State machine, count latch and round counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            round    <= '0;
            n_q      <= '0;
            rounds_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    n_q      <= n_len;
                    rounds_q <= rnd_need;
                    round    <= '0;
                    state    <= (rnd_need == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    if (round == last_rnd) state <= ST_FIN;
                    else                   round <= round + RND_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result capture and the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= (state == ST_FIN);
            if (state == ST_FIN) result <= elem0;
        end
    end

    // Status decode for the datapath and the port.
    always_comb begin
        run  = (state == ST_RUN);
        busy = (state != ST_IDLE);
    end

    assert_round_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (round < rounds_q));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && round != last_rnd) |=>
        (state == ST_RUN && round == $past(round) + RND_W'(1) && $stable(n_q)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
endmodule

// File: rtl/tr_array.sv
// Element storage with one adder per worker.
// Loads are accepted only while idle. During a running round, each active
// worker adds its partner element into its own even slot.
// Assumes the active mask comes from the eligibility decoder for this round.
module tr_array #(
    parameter int MAX_N  = 16,
    parameter int DATA_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ld_en,
    input  logic [$clog2(MAX_N)-1:0]           ld_addr,
    input  logic [DATA_W-1:0]                  ld_data,
    input  logic                               busy,
    input  logic                               run,
    input  logic [$clog2($clog2(MAX_N)+1)-1:0] round,
    input  logic [MAX_N/2-1:0]                 active,
    output logic [DATA_W-1:0]                  elem0
);
    localparam int IDX_W = $clog2(MAX_N);
    localparam int NW    = MAX_N / 2;

    logic [DATA_W-1:0]          mem [MAX_N];
    logic [NW-1:0][DATA_W-1:0]  pval;
    logic [NW-1:0][IDX_W:0]     pidx;
    logic [IDX_W:0]             stride;

    // Current stride as an index offset.
    always_comb stride = (IDX_W+1)'(1) << round;

    for (genvar i = 0; i < NW; i++) begin : g_pair
        // Partner index and value fetched by worker i.
        always_comb begin
            pidx[i] = (IDX_W+1)'(2 * i) + stride;
            if (active[i] && pidx[i] < (IDX_W+1)'(MAX_N))
                pval[i] = mem[pidx[i][IDX_W-1:0]];
            else
                pval[i] = '0;
        end
    end

    for (genvar k = 0; k < MAX_N; k++) begin : g_el
        if ((k % 2 == 0) && (k / 2 < NW)) begin : g_tgt
            // Even slot: idle load, or in-place add during a round.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[k] <= '0;
                else if (!busy && ld_en && ld_addr == IDX_W'(k))
                    mem[k] <= ld_data;
                else if (run && active[k/2])
                    mem[k] <= mem[k] + pval[k/2];
            end
        end else begin : g_src
            // Odd slot: written only by an idle load.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[k] <= '0;
                else if (!busy && ld_en && ld_addr == IDX_W'(k))
                    mem[k] <= ld_data;
            end
        end
    end

    assign elem0 = mem[0];

    logic [MAX_N-1:0] src_mask;
    logic [MAX_N-1:0] dst_mask;

    // Elements read and written by the active workers this cycle.
    always_comb begin
        src_mask = '0;
        dst_mask = '0;
        for (int i = 0; i < NW; i++) begin
            if (active[i]) begin
                dst_mask[2*i] = 1'b1;
                if (pidx[i] < (IDX_W+1)'(MAX_N)) src_mask[pidx[i][IDX_W-1:0]] = 1'b1;
            end
        end
    end

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((src_mask & dst_mask) == '0));

    assert_load_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !run) |=> $stable(elem0));
endmodule

// File: rtl/tree_reduce.sv
// Top of the in-place tree reduction engine.
// It wires the sequencer, the eligibility decoder and the element array.
// Assumes 1 <= n_len <= MAX_N at start, and MAX_N >= 2.
module tree_reduce #(
    parameter int MAX_N  = 16,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(MAX_N+1)-1:0] n_len,
    input  logic                       ld_en,
    input  logic [$clog2(MAX_N)-1:0]   ld_addr,
    input  logic [DATA_W-1:0]          ld_data,
    output logic                       busy,
    output logic                       done,
    output logic [DATA_W-1:0]          result
);
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam int RND_W = $clog2($clog2(MAX_N) + 1);

    logic [CNT_W-1:0]   n_q;
    logic [RND_W-1:0]   round;
    logic               run;
    logic [MAX_N/2-1:0] active;
    logic [DATA_W-1:0]  elem0;

    tr_ctrl #(.MAX_N(MAX_N), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len),
        .elem0(elem0), .n_q(n_q), .round(round), .run(run),
        .busy(busy), .done(done), .result(result)
    );

    tr_elig #(.MAX_N(MAX_N)) u_elig (
        .round(round), .n_q(n_q), .active(active)
    );

    tr_array #(.MAX_N(MAX_N), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .busy(busy), .run(run), .round(round),
        .active(active), .elem0(elem0)
    );
endmodule

// File: tb/tree_reduce_test.sv
`timescale 1ns/1ps
module tree_reduce_test;
    localparam int MAX_N  = 16;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4:0] n_len = '0;
    logic ld_en = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [DATA_W-1:0] ld_data = '0;
    logic busy, done;
    logic [DATA_W-1:0] result;

    int checks = 0;
    int failures = 0;
    logic [DATA_W-1:0] shadow [MAX_N];

    always #2.5 clk = ~clk;

    tree_reduce #(.MAX_N(MAX_N), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clog2n(input int n);
        int r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        ld_en = 1'b1; ld_addr = 4'(a); ld_data = d;
        shadow[a] = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic fill(input int seed);
        for (int k = 0; k < MAX_N; k++) wr(k, DATA_W'(seed * 7 + k * 13 + 1));
    endtask

    function automatic logic [DATA_W-1:0] sum_of(input int n);
        logic [DATA_W-1:0] s = '0;
        for (int k = 0; k < n; k++) s = s + shadow[k];
        return s;
    endfunction

    // Run one job; optional start and load requests injected while busy.
    task automatic run_job(input int n, input string req, input bit poke);
        logic [DATA_W-1:0] exp_sum;
        int cyc;
        exp_sum = sum_of(n);
        start = 1'b1; n_len = 5'(n);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3", "busy after start", busy, 1);
        cyc = 0;
        while (!done && cyc < 40) begin
            if (!done) chk(busy == 1'b1, "R3", "busy during job", busy, 1);
            if (poke && cyc == 0) begin
                start = 1'b1; n_len = 5'(2);
                ld_en = 1'b1; ld_addr = 4'd0; ld_data = 16'h1234;
            end
            @(negedge clk);
            start = 1'b0; ld_en = 1'b0;
            cyc++;
        end
        chk(cyc == clog2n(n) + 1, req, "cycles to done", cyc, clog2n(n) + 1);
        chk(busy == 1'b0, "R3", "busy low at done", busy, 0);
        chk(result == exp_sum, req, "result", result, exp_sum);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done one cycle", done, 0);
        chk(result == exp_sum, "R9", "result held", result, exp_sum);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R1", "busy reset", busy, 0);
        chk(done == 1'b0, "R1", "done reset", done, 0);
        chk(result == '0, "R1", "result reset", result, 0);
    endtask

    task automatic t_pow2;
        fill(1); run_job(8, "R4", 1'b0);
        fill(2); run_job(16, "R4", 1'b0);
        fill(3); run_job(2, "R4", 1'b0);
    endtask

    task automatic t_odd;
        fill(4); run_job(5, "R5", 1'b0);
        fill(5); run_job(3, "R5", 1'b0);
        fill(6); run_job(7, "R5", 1'b0);
        fill(7); run_job(13, "R5", 1'b0);
    endtask

    task automatic t_one;
        fill(8); run_job(1, "R6", 1'b0);
        chk(result == shadow[0], "R6", "element 0 unchanged", result, shadow[0]);
    endtask

    task automatic t_wrap;
        for (int k = 0; k < MAX_N; k++) wr(k, 16'hFFFF);
        run_job(4, "R7", 1'b0);
        chk(result == 16'hFFFC, "R7", "wrap value", result, 16'hFFFC);
    endtask

    task automatic t_busy_req;
        fill(9); run_job(8, "R8", 1'b1);
        fill(10); run_job(6, "R2", 1'b1);
    endtask

    task automatic t_hold;
        logic [DATA_W-1:0] keep;
        keep = result;
        repeat (3) @(negedge clk);
        wr(0, 16'h0BAD); wr(1, 16'h0123);
        chk(result == keep, "R9", "result after reload", result, keep);
        chk(done == 1'b0, "R10", "no done on reload", done, 0);
        run_job(2, "R2", 1'b0);
        chk(result == 16'h0CD0, "R2", "loaded values used", result, 16'h0CD0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pow2();
        t_odd();
        t_one();
        t_wrap();
        t_busy_req();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule